// File: doc/BRIEF.md
# NAND Page Reed-Solomon Parity Engine

This block computes a six-symbol Reed-Solomon parity over one NAND page as its bytes pass between a host and the flash. Symbols are 10 bits wide over GF(2^10), built on the primitive polynomial x^10 + x^3 + 1 (0x409). The generator polynomial is the product of (x + alpha^i) for i = 0 to 5. Every data byte is inverted and zero-extended to a 10-bit symbol before it enters the divider, so an erased page (all 0xFF) gives an all-ones parity.

The host controls the engine through a three-bit control write: bit 7 clears it, bit 6 selects generate (write) mode when set and check (read) mode when clear, and bit 5 enables byte absorption. In generate mode the first page of strobed bytes is divided and the parity is read back as eight packed code bytes. In check mode the page is followed by the eight stored code bytes. The engine then sets an error flag when the stored code differs from the recomputed one, which is the same as a nonzero remainder of the whole codeword. A second read window returns that remainder with the bits of each byte reversed, for a correction routine in software.

Top module: `rs_page_ecc`

## Requirements
- R1: After reset, code bytes at read addresses 0 to 7 all read 0xFF, the status byte at address 16 reads 0x00, absorption is disabled and check mode is selected.
- R2: A control write with bit 7 set zeroes the parity state, the byte count, the stored bytes and the error flag at that clock edge, and a data strobe in the same cycle is not absorbed.
- R3: A data strobe is absorbed only while control bit 5 was set by the last control write; other strobes leave every readable byte unchanged.
- R4: Each data byte b enters the divider as the symbol {2'b00, ~b}, so a page of 0xFF bytes leaves all eight code bytes at 0xFF.
- R5: The parity is the remainder of D(x)·x^6 modulo g(x), where g(x) is the product of (x + alpha^i) for i = 0 to 5, alpha is the root of x^10 + x^3 + 1, and the first byte of the page is the highest-degree data symbol.
- R6: Parity coefficient j (of x^j) occupies bits 10j+9 down to 10j of a 64-bit word; code byte k, at read address k, is the inverse of bits 8k+7 down to 8k, so bits 63 to 60 (the top nibble of byte 7) read as ones.
- R7: In generate mode only the first PAGE_BYTES absorbed strobes after a clear enter the divider; later strobes change nothing.
- R8: In check mode the eight strobes after the page are captured as stored bytes 0 to 7 in arrival order; strobes after that change nothing.
- R9: The status byte bit 7 is set on the clock edge that absorbs the eighth stored byte when bits 59 to 0 of the code and stored words differ. It is never set earlier, and it stays set until the next clear.
- R10: Read address 8+k returns byte k of (code XOR stored) with its bit order reversed, so bit 0 of that byte appears as bit 7.
- R11: Read addresses 17 to 31 return 0x00, and status bits 6 to 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | Control bits 7..5: clear, generate mode, absorb enable |
| dat_stb | input | 1 | Page or stored-code byte valid this cycle |
| dat_byte | input | 8 | Byte passing to or from the flash |
| rd_addr | input | 5 | Read address: 0-7 code, 8-15 reversed remainder, 16 status |
| rd_data | output | 8 | Combinational read data |

## Verification
Every strobe or control write takes effect at the next rising edge, and the read port is combinational. Code bytes, remainder bytes and the status flag can therefore be read from the falling edge that follows the edge absorbing the last relevant byte. The bench drives inputs and reads results only on falling edges. In check mode it reads the status after the seventh stored byte, where the flag must still be clear, and again one cycle later, after the eighth, where it must carry the verdict. Strobes sent beyond the page or the code are followed by a fresh read of every window, which shows that none of them had an effect.

// File: rtl/rs_ecc_pkg.sv
// Package: shared widths and GF(2^10) arithmetic for the page parity engine.
// Assumes a primitive field polynomial and roots alpha^0 .. alpha^(NPAR-1).
package rs_ecc_pkg;

    localparam int              SYM_W      = 10;
    localparam int              NPAR       = 6;
    localparam logic [SYM_W:0]  PRIM_POLY  = 11'h409;
    localparam int              CODE_BYTES = 8;
    localparam int              PACK_W     = CODE_BYTES * 8;
    localparam int              PAR_W      = NPAR * SYM_W;
    localparam int              RA_W       = 5;

    typedef logic [SYM_W-1:0] sym_t;

    // Field product by shift-and-add with reduction on every shift.
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            if (sh[SYM_W-1]) sh = (sh << 1) ^ PRIM_POLY[SYM_W-1:0];
            else             sh = sh << 1;
        end
        return acc;
    endfunction

    // Coefficient k of the monic generator polynomial prod (x + alpha^i).
    function automatic sym_t gen_coef(int k);
        logic [NPAR:0][SYM_W-1:0] g;
        sym_t root;
        g    = '0;
        g[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < NPAR; i++) begin
            for (int j = i + 1; j >= 1; j--) begin
                g[j] = g[j-1] ^ gf_mul(g[j], root);
            end
            g[0] = gf_mul(g[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        return g[k];
    endfunction

endpackage

// File: rtl/rs_lfsr.sv
// Module: systematic Reed-Solomon divider, one symbol per shifted cycle.
// Assumes the generator coefficients are constants; each stage is a fixed
// constant multiplier. Holds the remainder of D(x)*x^NPAR mod g(x).
module rs_lfsr
    import rs_ecc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  sym_t             sym_in,
    output logic [PAR_W-1:0] par_o
);

    sym_t rem_q [NPAR];
    sym_t fb;

    // Feedback: incoming symbol plus the highest remainder coefficient.
    always_comb fb = sym_in ^ rem_q[NPAR-1];

    for (genvar j = 0; j < NPAR; j++) begin : g_stage
        localparam sym_t GC = gen_coef(j);
        if (j == 0) begin : g_low
            // Lowest stage takes only the scaled feedback.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  rem_q[j] <= '0;
                else if (shift)     rem_q[j] <= gf_mul(fb, GC);
            end
        end else begin : g_mid
            // Higher stages add the scaled feedback to the stage below.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)  rem_q[j] <= '0;
                else if (shift)     rem_q[j] <= rem_q[j-1] ^ gf_mul(fb, GC);
            end
        end
        assign par_o[j*SYM_W +: SYM_W] = rem_q[j];
    end

endmodule

// File: rtl/rs_ecc_seq.sv
// Module: control register, byte counter, stored-code capture and error flag.
// Assumes bytes arrive in page order, followed in check mode by code byte 0..7.
module rs_ecc_seq
    import rs_ecc_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int CW         = $clog2(PAGE_BYTES + CODE_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:5]        ctl_wdata,
    input  logic              dat_stb,
    input  logic [7:0]        dat_byte,
    input  logic [PAR_W-1:0]  par_i,
    output logic              clr_o,
    output logic              shift_o,
    output sym_t              sym_o,
    output logic [PACK_W-1:0] stored_o,
    output logic              err_o,
    output logic              gen_o,
    output logic              feed_o,
    output logic [CW-1:0]     cnt_o
);

    localparam logic [CW-1:0] DATA_END = CW'(PAGE_BYTES);
    localparam logic [CW-1:0] PAR_END  = CW'(PAGE_BYTES + CODE_BYTES);
    localparam logic [CW-1:0] LAST_PAR = CW'(PAGE_BYTES + CODE_BYTES - 1);

    logic              gen_q, feed_q, err_q;
    logic [CW-1:0]     cnt_q;
    logic [PACK_W-1:0] stored_q, stored_nxt;
    logic              take, in_data, in_par;

    // Decode which phase an accepted strobe belongs to.
    always_comb begin
        clr_o      = ctl_we & ctl_wdata[7];
        take       = dat_stb & feed_q & ~clr_o;
        in_data    = cnt_q < DATA_END;
        in_par     = ~gen_q & (cnt_q >= DATA_END) & (cnt_q < PAR_END);
        shift_o    = take & in_data;
        sym_o      = {{(SYM_W-8){1'b0}}, ~dat_byte};
        stored_nxt = {dat_byte, stored_q[PACK_W-1:8]};
    end

    // Mode bits follow every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q  <= 1'b0;
            feed_q <= 1'b0;
        end else if (ctl_we) begin
            gen_q  <= ctl_wdata[6];
            feed_q <= ctl_wdata[5];
        end
    end

    // Count absorbed bytes, saturating at the end of the active phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_o)                  cnt_q <= '0;
        else if (take && (in_data || in_par)) cnt_q <= cnt_q + 1'b1;
    end

    // Shift stored code bytes in, first byte ending in the lowest lane.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_o)      stored_q <= '0;
        else if (take && in_par)  stored_q <= stored_nxt;
    end

    // Compare recomputed and stored code as the last stored byte lands.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_o)
            err_q <= 1'b0;
        else if (take && in_par && cnt_q == LAST_PAR)
            err_q <= |(~par_i ^ stored_nxt[PAR_W-1:0]);
    end

    assign stored_o = stored_q;
    assign err_o    = err_q;
    assign gen_o    = gen_q;
    assign feed_o   = feed_q;
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/rs_ecc_view.sv
// Module: packs parity into code bytes and serves the read windows.
// Assumes parity coefficient j sits at bits 10j+9..10j of the packed word.
module rs_ecc_view
    import rs_ecc_pkg::*;
(
    input  logic [PAR_W-1:0]  par_i,
    input  logic [PACK_W-1:0] stored_i,
    input  logic              err_i,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [7:0]        rd_data
);

    logic [PACK_W-1:0] code, rem;
    logic [7:0]        rem_byte;

    // Inverted parity with ones in the unused lanes, and its difference.
    always_comb begin
        code = {{(PACK_W-PAR_W){1'b1}}, ~par_i};
        rem  = code ^ stored_i;
    end

    // Select one remainder byte and reverse its bit order.
    always_comb begin
        for (int b = 0; b < 8; b++) rem_byte[b] = rem[{rd_addr[2:0], 3'b000} + 6'(7 - b)];
    end

    // Address decode across code, remainder and status windows.
    always_comb begin
        case (rd_addr[4:3])
            2'b00:   rd_data = code[{rd_addr[2:0], 3'b000} +: 8];
            2'b01:   rd_data = rem_byte;
            2'b10:   rd_data = (rd_addr[2:0] == 3'd0) ? {err_i, 7'b0} : 8'h00;
            default: rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/rs_page_ecc.sv
// Module: top of the NAND page Reed-Solomon parity engine.
// Assumes the host issues a clear before each page and keeps byte order.
module rs_page_ecc
    import rs_ecc_pkg::*;
#(
    parameter int PAGE_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [7:5]  ctl_wdata,
    input  logic        dat_stb,
    input  logic [7:0]  dat_byte,
    input  logic [4:0]  rd_addr,
    output logic [7:0]  rd_data
);

    localparam int CW = $clog2(PAGE_BYTES + CODE_BYTES + 1);

    logic              clr, shift, err_q, gen_q, feed_q;
    sym_t              sym;
    logic [PAR_W-1:0]  par_q;
    logic [PACK_W-1:0] stored_q;
    logic [CW-1:0]     cnt_q;

    rs_ecc_seq #(.PAGE_BYTES(PAGE_BYTES), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_stb(dat_stb), .dat_byte(dat_byte), .par_i(par_q),
        .clr_o(clr), .shift_o(shift), .sym_o(sym), .stored_o(stored_q),
        .err_o(err_q), .gen_o(gen_q), .feed_o(feed_q), .cnt_o(cnt_q)
    );

    rs_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift(shift),
        .sym_in(sym), .par_o(par_q)
    );

    rs_ecc_view u_view (
        .par_i(par_q), .stored_i(stored_q), .err_i(err_q),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/rs_page_ecc_chk.sv
// Checker: temporal properties of the page parity engine, bound to the top.
module rs_page_ecc_chk #(
    parameter int PAGE_BYTES = 512,
    parameter int CW         = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_we,
    input logic [7:5]    ctl_wdata,
    input logic          feed_q,
    input logic          gen_q,
    input logic          err_q,
    input logic [CW-1:0] cnt_q,
    input logic [59:0]   par_q,
    input logic [4:0]    rd_addr,
    input logic [7:0]    rd_data
);

    logic clr_w;
    assign clr_w = ctl_we & ctl_wdata[7];

    // R2
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (cnt_q == '0 && !err_q && par_q == '0));

    // R3
    nofeed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!feed_q && !clr_w) |=> ($stable(par_q) && $stable(cnt_q)));

    // R7
    write_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q && cnt_q == CW'(PAGE_BYTES) && !clr_w) |=> $stable(par_q));

    // R9
    err_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ($past(cnt_q) == CW'(PAGE_BYTES + 7) && !$past(gen_q)));

    // R6
    pad_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 5'd7) |-> (rd_data[7:4] == 4'hF));

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > 5'd16) |-> (rd_data == 8'h00));

endmodule

bind rs_page_ecc rs_page_ecc_chk #(.PAGE_BYTES(PAGE_BYTES), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .feed_q(feed_q), .gen_q(gen_q), .err_q(err_q), .cnt_q(cnt_q),
    .par_q(par_q), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_rs_page_ecc.sv
// Directed bench for the page parity engine; one task per scenario.
module tb_rs_page_ecc;

    localparam int PAGE = 512;

    logic       clk = 1'b0;
    logic       rst_n, ctl_we, dat_stb;
    logic [7:5] ctl_wdata;
    logic [7:0] dat_byte, rd_data;
    logic [4:0] rd_addr;

    int checks = 0;
    int errors = 0;

    logic [7:0] page [PAGE];
    logic [9:0] gc [7];

    always #5 clk = ~clk;

    rs_page_ecc #(.PAGE_BYTES(PAGE)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dat_stb(dat_stb), .dat_byte(dat_byte), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // ---------------- reference model ----------------
    function automatic logic [9:0] fmul(logic [9:0] a, logic [9:0] b);
        logic [19:0] p = '0;
        for (int i = 0; i < 10; i++) if (b[i]) p = p ^ (20'(a) << i);
        for (int i = 19; i >= 10; i--) if (p[i]) p = p ^ (20'h409 << (i - 10));
        return p[9:0];
    endfunction

    function automatic logic [7:0] rev8(logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    task automatic build_gen();
        logic [9:0] root = 10'd1;
        for (int i = 0; i < 7; i++) gc[i] = '0;
        gc[0] = 10'd1;
        for (int i = 0; i < 6; i++) begin
            for (int j = i + 1; j >= 1; j--) gc[j] = gc[j-1] ^ fmul(gc[j], root);
            gc[0] = fmul(gc[0], root);
            root = fmul(root, 10'd2);
        end
    endtask

    function automatic logic [63:0] ref_code();
        logic [9:0] r [6];
        logic [9:0] fb;
        logic [59:0] p;
        for (int j = 0; j < 6; j++) r[j] = '0;
        for (int i = 0; i < PAGE; i++) begin
            fb = {2'b00, ~page[i]} ^ r[5];
            for (int j = 5; j >= 1; j--) r[j] = r[j-1] ^ fmul(fb, gc[j]);
            r[0] = fmul(fb, gc[0]);
        end
        for (int j = 0; j < 6; j++) p[j*10 +: 10] = r[j];
        return {4'hF, ~p};
    endfunction

    // ---------------- drivers ----------------
    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctl_wr(logic [7:5] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        dat_stb = 1'b1; dat_byte = b;
        @(negedge clk);
        dat_stb = 1'b0;
    endtask

    task automatic send_page();
        for (int i = 0; i < PAGE; i++) begin
            @(negedge clk);
            dat_stb = 1'b1; dat_byte = page[i];
        end
        @(negedge clk);
        dat_stb = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic rd_win(logic [4:0] base, output logic [63:0] w);
        logic [7:0] d;
        for (int k = 0; k < 8; k++) begin
            rd(base + 5'(k), d);
            w[k*8 +: 8] = d;
        end
    endtask

    function automatic logic [63:0] rev_all(logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = rev8(v[k*8 +: 8]);
        return r;
    endfunction

    task automatic fill(int seed);
        for (int i = 0; i < PAGE; i++) page[i] = 8'((i * seed) ^ (i >> 3) ^ (seed * 29));
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [63:0] w;
        logic [7:0] s;
        rd_win(5'd0, w);
        check("R1 code after reset", w, {64{1'b1}});
        rd(5'd16, s);
        check("R1 status after reset", 64'(s), 64'h0);
        send_byte(8'h12);
        rd_win(5'd0, w);
        check("R1 absorb disabled after reset", w, {64{1'b1}});
    endtask

    task automatic t_blank();
        logic [63:0] w;
        for (int i = 0; i < PAGE; i++) page[i] = 8'hFF;
        ctl_wr(3'b111);
        send_page();
        rd_win(5'd0, w);
        check("R4 erased page code", w, {64{1'b1}});
        rd_win(5'd8, w);
        check("R10 remainder of erased page", w, {64{1'b1}});
    endtask

    task automatic t_ref(int seed);
        logic [63:0] w, e;
        fill(seed);
        e = ref_code();
        ctl_wr(3'b111);
        send_page();
        rd_win(5'd0, w);
        check("R5 R6 code bytes vs model", w, e);
        check("R6 byte7 top nibble ones", 64'(w[63:60]), 64'hF);
    endtask

    task automatic t_feed_off();
        logic [63:0] w;
        fill(5);
        ctl_wr(3'b110);
        for (int i = 0; i < 10; i++) send_byte(8'(i * 37));
        rd_win(5'd0, w);
        check("R3 strobes ignored with absorb off", w, {64{1'b1}});
        ctl_wr(3'b011);
        ctl_wr(3'b010);
        send_byte(8'h5A);
        rd_win(5'd0, w);
        check("R3 absorb off after write of zero feed", w, {64{1'b1}});
        ctl_wr(3'b011);
        send_page();
        rd_win(5'd0, w);
        check("R3 only enabled bytes counted", w, ref_code());
    endtask

    task automatic t_clear_prio();
        logic [63:0] w;
        fill(9);
        ctl_wr(3'b111);
        send_byte(8'h3C);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 3'b111;
        dat_stb = 1'b1; dat_byte = 8'h00;
        @(negedge clk);
        ctl_we = 1'b0; dat_stb = 1'b0;
        rd_win(5'd0, w);
        check("R2 clear wins over strobe", w, {64{1'b1}});
        send_page();
        rd_win(5'd0, w);
        check("R2 page after clear", w, ref_code());
    endtask

    task automatic t_overrun();
        logic [63:0] w;
        fill(11);
        ctl_wr(3'b111);
        send_page();
        for (int i = 0; i < 5; i++) send_byte(8'(i + 1));
        rd_win(5'd0, w);
        check("R7 extra bytes after page ignored", w, ref_code());
    endtask

    task automatic t_check(int seed, int bad_data, int bad_par);
        logic [63:0] good, stored, got, exp_rem, w;
        logic [7:0] s;
        logic err_exp;
        fill(seed);
        good = ref_code();
        stored = good;
        if (bad_par >= 0) stored[bad_par*8 +: 8] = stored[bad_par*8 +: 8] ^ 8'h01;
        if (bad_data >= 0) page[bad_data] = page[bad_data] ^ 8'h40;
        got = ref_code();
        exp_rem = got ^ stored;
        err_exp = |exp_rem[59:0];
        ctl_wr(3'b101);
        send_page();
        for (int k = 0; k < 7; k++) send_byte(stored[k*8 +: 8]);
        rd(5'd16, s);
        check("R9 flag clear before last stored byte", 64'(s), 64'h0);
        send_byte(stored[63:56]);
        rd(5'd16, s);
        check("R9 flag one cycle after last stored byte", 64'(s), {56'h0, err_exp, 7'b0});
        rd_win(5'd8, w);
        check("R10 R8 reversed remainder window", w, rev_all(exp_rem));
        for (int i = 0; i < 3; i++) send_byte(8'hA5);
        rd_win(5'd8, w);
        check("R8 bytes after stored code ignored", w, rev_all(exp_rem));
        rd(5'd16, s);
        check("R9 flag holds until clear", 64'(s), {56'h0, err_exp, 7'b0});
        ctl_wr(3'b100);
        rd(5'd16, s);
        check("R2 clear drops flag", 64'(s), 64'h0);
    endtask

    task automatic t_addr();
        logic [7:0] d;
        for (int a = 17; a < 32; a++) begin
            rd(5'(a), d);
            check("R11 unmapped address", 64'(d), 64'h0);
        end
    endtask

    task automatic run_all();
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        dat_stb = 1'b0; dat_byte = '0; rd_addr = '0;
        build_gen();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_blank();
        t_ref(3);
        t_ref(0);
        t_feed_off();
        t_clear_prio();
        t_overrun();
        t_check(7, -1, -1);
        t_check(13, -1, 2);
        t_check(17, 100, -1);
        t_addr();
    endtask

    initial begin
        fork
            run_all();
            begin
                #1_500_000;
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule